// File: doc/BRIEF.md
# EEPROM Page-Write Address Controller

This block sits between a serial-bus front end and the storage array of a 256 x 8 EEPROM core. The front end decodes bus traffic into single-cycle events. The events are: start, stop (with a flag telling whether the stop followed the acknowledge of a complete data byte), word address received, data byte received, and data byte sent. The block keeps the word-address counter and collects incoming write bytes in a 16-byte page staging buffer. On a valid stop it runs a timed internal write cycle, and it places the byte at the current address on its read-data output.

Writes stay inside one 16-byte page: only the four low address bits advance, so bytes beyond the sixteenth overwrite earlier ones in the same page. Reads advance the full 8-bit counter and wrap from the top of the array to zero. The counter keeps its value between transactions, which supports current-address reads. A single write-allowed input stands in for every protection rule.

At most one event input is high in any clock cycle. If several are high, the order of precedence is stop, start, word address, data received, data sent. While a write cycle is running, every event is ignored.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset every one of the 256 locations reads FFh, the address counter is 00h and busy is low.
- R2: A word-address event loads the counter with `ev_byte`. A transfer that has a word address and no data byte, closed by a stop, starts no write cycle and changes no location.
- R3: Each accepted data byte advances only address bits [3:0], wrapping from 1111b to 0000b, and leaves bits [7:4] unchanged.
- R4: When more than 16 bytes are sent in one transfer, each page slot holds the last byte received for it.
- R5: Each data-sent event adds one to the full 8-bit counter, wrapping from FFh to 00h, and `rd_data` always shows the location at the counter.
- R6: A write cycle starts only on a stop with `stop_at_ack` high after at least one byte was staged. A stop with `stop_at_ack` low discards the staged bytes.
- R7: Busy stays high for exactly WR_CYCLES clock cycles after the stop that starts a write cycle. The staged bytes appear in the array when busy falls.
- R8: A write cycle changes only the page locations that received a byte in that transfer.
- R9: With `wr_allow` low, a data-received event returns `wr_ack` low, does not move the counter and stages nothing.
- R10: While busy is high, all events are ignored: `wr_ack` stays low and the counter does not move.
- R11: A start event discards any bytes staged since the last word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| stop_at_ack | input | 1 | Qualifies `bus_stop`: the stop followed the acknowledge of a full data byte |
| ev_addr_load | input | 1 | Word-address byte received |
| ev_wr_byte | input | 1 | Write data byte received |
| ev_rd_byte | input | 1 | Read data byte fully sent |
| ev_byte | input | 8 | Word address or data byte for the current event |
| wr_allow | input | 1 | Writes permitted |
| wr_ack | output | 1 | Data-received event accepted (combinational) |
| rd_data | output | 8 | Array contents at the address counter |
| addr_out | output | 8 | Current address counter |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The main function is driven with a single byte write, a partial page that crosses the page end, an overrun of 18 bytes, and a two-byte partial page. Together these separate in-page wrap from full-address carry, last-writer-wins from first-writer-wins, and a masked update from a whole-page rewrite. A full read scan and a read that crosses FFh show whether the read counter carries into the upper bits. Stops without the acknowledge flag, dummy writes, start-abandoned transfers, blocked writes and events sent during busy each confirm that these paths leave the array and the counter unchanged.

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int PW        = 4,
  parameter int WR_CYCLES = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          stop_at_ack,
  input  logic          ev_addr_load,
  input  logic          ev_wr_byte,
  input  logic          ev_rd_byte,
  input  logic [DW-1:0] ev_byte,
  input  logic          wr_allow,
  output logic          wr_ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr_out,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int PSIZE = 1 << PW;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  logic [DW-1:0]    mem   [DEPTH];
  logic [DW-1:0]    stage [PSIZE];
  logic [PSIZE-1:0] vmask;
  logic [AW-1:0]    addr;
  logic             busy_q;
  logic [TW-1:0]    tmr;

  wire idle     = !busy_q;
  wire done     = busy_q && (tmr == '0);
  wire take_wr  = idle && !bus_stop && !bus_start && !ev_addr_load && ev_wr_byte && wr_allow;
  wire take_rd  = idle && !bus_stop && !bus_start && !ev_addr_load && !ev_wr_byte && ev_rd_byte;
  wire commit   = idle && bus_stop && stop_at_ack && (|vmask);
  wire [PW-1:0] slot = addr[PW-1:0];

  assign wr_ack   = take_wr;
  assign rd_data  = mem[addr];
  assign addr_out = addr;
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      busy_q <= 1'b0;
      tmr    <= '0;
      vmask  <= '0;
    end else if (busy_q) begin
      tmr <= tmr - 1'b1;
      if (done) begin
        busy_q <= 1'b0;
        vmask  <= '0;
      end
    end else if (bus_stop) begin
      if (commit) begin
        busy_q <= 1'b1;
        tmr    <= TW'(WR_CYCLES - 1);
      end else begin
        vmask <= '0;
      end
    end else if (bus_start) begin
      vmask <= '0;
    end else if (ev_addr_load) begin
      addr  <= ev_byte[AW-1:0];
      vmask <= '0;
    end else if (take_wr) begin
      vmask[slot] <= 1'b1;
      addr        <= {addr[AW-1:PW], slot + 1'b1};
    end else if (take_rd) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_wr) stage[slot] <= ev_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (done) begin
      for (int j = 0; j < PSIZE; j++)
        if (vmask[j]) mem[{addr[AW-1:PW], PW'(j)}] <= stage[j];
    end
  end
endmodule

// File: rtl/eeprom_page_ctrl_chk.sv
module eeprom_page_ctrl_chk #(
  parameter int AW        = 8,
  parameter int WR_CYCLES = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          stop_at_ack,
  input logic          ev_addr_load,
  input logic          ev_wr_byte,
  input logic          ev_rd_byte,
  input logic          wr_allow,
  input logic          wr_ack,
  input logic [AW-1:0] addr_out,
  input logic          busy
);
  int busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  a_r3_page_inc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (addr_out[AW-1:4] == $past(addr_out[AW-1:4])) &&
               (addr_out[3:0] == 4'($past(addr_out[3:0]) + 4'd1)));

  a_r5_read_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_byte && !busy && !bus_stop && !bus_start && !ev_addr_load && !ev_wr_byte)
      |=> addr_out == AW'($past(addr_out) + 1'b1));

  a_r6_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop && stop_at_ack));

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == WR_CYCLES);

  a_r9_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_byte && !wr_allow && !ev_addr_load && !ev_rd_byte) |=> $stable(addr_out));

  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_out));

  a_r10_busy_noack: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ack);
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .stop_at_ack(stop_at_ack), .ev_addr_load(ev_addr_load), .ev_wr_byte(ev_wr_byte),
  .ev_rd_byte(ev_rd_byte), .wr_allow(wr_allow), .wr_ack(wr_ack),
  .addr_out(addr_out), .busy(busy)
);

// File: tb/eeprom_page_ctrl_test.sv
module eeprom_page_ctrl_test;
  localparam int W = 24;

  logic clk = 0, rst_n = 0;
  logic bus_start = 0, bus_stop = 0, stop_at_ack = 0;
  logic ev_addr_load = 0, ev_wr_byte = 0, ev_rd_byte = 0, wr_allow = 1;
  logic [7:0] ev_byte = 0;
  logic wr_ack, busy;
  logic [7:0] rd_data, addr_out;

  always #4 clk = ~clk;

  eeprom_page_ctrl #(.WR_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .stop_at_ack(stop_at_ack), .ev_addr_load(ev_addr_load), .ev_wr_byte(ev_wr_byte),
    .ev_rd_byte(ev_rd_byte), .ev_byte(ev_byte), .wr_allow(wr_allow), .wr_ack(wr_ack),
    .rd_data(rd_data), .addr_out(addr_out), .busy(busy));

  int compared = 0, mismatched = 0;
  bit done_flag = 0;

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int mm[256];
  int ma, mb;
  int sg[16];
  bit sv[16];

  function automatic bit any_sv();
    foreach (sv[i]) if (sv[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mm[i]) mm[i] = 255;
      ma = 0; mb = 0;
      foreach (sv[i]) sv[i] = 0;
    end else if (mb > 0) begin
      mb--;
      if (mb == 0) begin
        foreach (sv[i]) if (sv[i]) mm[(ma & 240) | i] = sg[i];
        foreach (sv[i]) sv[i] = 0;
      end
    end else if (bus_stop) begin
      if (stop_at_ack && any_sv()) mb = W;
      else foreach (sv[i]) sv[i] = 0;
    end else if (bus_start) begin
      foreach (sv[i]) sv[i] = 0;
    end else if (ev_addr_load) begin
      ma = ev_byte;
      foreach (sv[i]) sv[i] = 0;
    end else if (ev_wr_byte && wr_allow) begin
      sg[ma & 15] = ev_byte; sv[ma & 15] = 1;
      ma = (ma & 240) | ((ma + 1) & 15);
    end else if (ev_rd_byte) begin
      ma = (ma + 1) % 256;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      automatic bit eack = ev_wr_byte && wr_allow && (mb == 0) &&
                           !bus_stop && !bus_start && !ev_addr_load;
      chk("R7 busy vs model", busy, mb > 0);
      chk("R3 addr vs model", addr_out, ma);
      chk("R5 rd_data vs model", rd_data, mm[ma]);
      chk("R9 wr_ack vs model", wr_ack, eack);
    end
  end

  task automatic clr();
    bus_start = 0; bus_stop = 0; stop_at_ack = 0;
    ev_addr_load = 0; ev_wr_byte = 0; ev_rd_byte = 0;
  endtask
  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; clr(); @(negedge clk); end
  endtask
  task automatic do_load(int a);
    @(posedge clk); #2; clr(); ev_addr_load = 1; ev_byte = 8'(a); @(negedge clk);
  endtask
  task automatic do_wr(int d);
    @(posedge clk); #2; clr(); ev_wr_byte = 1; ev_byte = 8'(d); @(negedge clk);
  endtask
  task automatic do_rd();
    @(posedge clk); #2; clr(); ev_rd_byte = 1; @(negedge clk);
  endtask
  task automatic do_stop(bit at_ack);
    @(posedge clk); #2; clr(); bus_stop = 1; stop_at_ack = at_ack; @(negedge clk);
  endtask
  task automatic do_start();
    @(posedge clk); #2; clr(); bus_start = 1; @(negedge clk);
  endtask
  task automatic wait_idle();
    while (busy) idle(1);
  endtask
  task automatic peek(int a, int exp, string tag);
    do_load(a); idle(1); chk(tag, rd_data, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R1 reset addr", addr_out, 0);
    chk("R1 reset busy", busy, 0);
    // R1/R5: full scan reads FF and wraps to 00
    for (int i = 0; i < 256; i++) begin
      chk("R1 initial content", rd_data, 8'hFF);
      do_rd();
    end
    idle(1);
    chk("R5 read wrap FF->00", addr_out, 0);

    // R6/R7: byte write
    do_load(8'h35); do_wr(8'hA1);
    chk("R9 ack when allowed", wr_ack, 1);
    do_stop(1); idle(1);
    begin
      int n = 0;
      while (busy) begin n++; idle(1); end
      chk("R7 busy length", n, W);
    end
    chk("R3 addr after byte write", addr_out, 8'h36);
    peek(8'h35, 8'hA1, "R6 byte committed");

    // R3: page wrap from 7C
    do_load(8'h7C);
    for (int i = 0; i < 6; i++) do_wr(8'h10 + i);
    idle(1);
    chk("R3 addr wraps in page", addr_out, 8'h72);
    do_stop(1); idle(1); wait_idle();
    peek(8'h7F, 8'h13, "R3 slot 7F");
    peek(8'h70, 8'h14, "R3 slot 70 after wrap");
    peek(8'h80, 8'hFF, "R3 next page untouched");

    // R4: 18 bytes at 40
    do_load(8'h40);
    for (int i = 0; i < 18; i++) do_wr(8'hC0 + i);
    do_stop(1); idle(1); wait_idle();
    peek(8'h40, 8'hD0, "R4 overwrite slot 0");
    peek(8'h41, 8'hD1, "R4 overwrite slot 1");
    peek(8'h42, 8'hC2, "R4 slot 2 kept");

    // R8: partial page
    do_load(8'h90); do_wr(8'h5A); do_wr(8'h5B);
    do_stop(1); idle(1); wait_idle();
    peek(8'h91, 8'h5B, "R8 written slot");
    peek(8'h92, 8'hFF, "R8 unwritten slot");
    peek(8'h9F, 8'hFF, "R8 unwritten last slot");

    // R6: stop mid-byte discards
    do_load(8'h20); do_wr(8'h77); do_stop(0); idle(1);
    chk("R6 no busy on bad stop", busy, 0);
    do_stop(1); idle(1);
    chk("R6 discarded bytes not committed", busy, 0);
    peek(8'h20, 8'hFF, "R6 location unchanged");

    // R2: dummy write
    do_load(8'h10); do_stop(1); idle(1);
    chk("R2 dummy no busy", busy, 0);
    chk("R2 counter loaded", addr_out, 8'h10);
    chk("R2 content unchanged", rd_data, 8'hFF);

    // R11: start discards
    do_load(8'h60); do_wr(8'h33); do_start(); do_stop(1); idle(1);
    chk("R11 no busy after start", busy, 0);
    peek(8'h60, 8'hFF, "R11 location unchanged");

    // R9: blocked writes
    wr_allow = 0;
    do_load(8'hB0); do_wr(8'h44);
    chk("R9 ack low when blocked", wr_ack, 0);
    idle(1);
    chk("R9 counter unmoved", addr_out, 8'hB0);
    do_stop(1); idle(1);
    chk("R9 no busy", busy, 0);
    wr_allow = 1;
    peek(8'hB0, 8'hFF, "R9 location unchanged");

    // R10: events during busy ignored
    do_load(8'hC4); do_wr(8'h99); do_stop(1);
    do_load(8'h05);
    do_wr(8'h11);
    chk("R10 ack low while busy", wr_ack, 0);
    do_rd(); idle(1);
    chk("R10 counter held", addr_out, 8'hC5);
    wait_idle();
    peek(8'hC4, 8'h99, "R10 write still lands");
    peek(8'hC5, 8'hFF, "R10 ignored byte not staged");

    // R5: sequential read across FF
    do_load(8'hFE); do_rd(); do_rd(); idle(1);
    chk("R5 seq read wrap", addr_out, 8'h00);
    do_rd(); idle(1);
    chk("R5 increment", addr_out, 8'h01);

    idle(2);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule